// File: doc/BRIEF.md
# Divergence Mask Stack

This block keeps the per-lane execution mask for one 64-item wavefront that runs on a 16-lane datapath, together with a stack of saved masks used for nested divergent branches. Every instruction of the wavefront is issued as four 16-lane quarters in ascending order. The block presents the active-lane bits for the quarter being issued in that cycle, so that lanes whose bit is clear do not commit results.

The sequencer gives the block a control operation, the 64-bit per-lane compare outcome, a pop count, the current program counter and a jump target. Four operations change the mask state. A save pushes the current mask. A predicate narrows the mask to the lanes whose compare outcome is set. An else turns the mask into the lanes that the saved mask enabled and the current mask does not. A jump branches to its target when no lane is still active, and as it branches it discards a given number of saved levels and restores the mask from the deepest level it discards. The block reports whether the branch is taken and which program counter comes next. Pushing onto a full stack and popping from an empty one are flagged.

Top module: `dmask_unit`

## Requirements
- R1: While reset is held, and at its release, the mask is all ones, the stack holds no entries, both error flags are low and the quarter index is 0.
- R2: The quarter index repeats 0,1,2,3 one step per clock, and the quarter output in a cycle with index q carries mask lanes 16q to 16q+15, with lane 16q on bit 0.
- R3: An operation is accepted only in a cycle whose quarter index is 3, and its effect is visible from the next cycle, which is quarter 0. An operation presented in any other cycle is ignored. The operation encodings are: 0 none, 1 save, 2 predicate, 3 else, 4 jump. Codes 5 to 7 act as none.
- R4: A save (code 1) on a stack that is not full stores the current mask as the new top entry and leaves the mask unchanged.
- R5: A predicate (code 2) sets the mask to the current mask AND the 64-bit compare outcome.
- R6: An else (code 3) on a stack that is not empty sets the mask to the top entry AND NOT the current mask. The stack keeps its entries.
- R7: In an accepted jump (code 4), the branch-taken output is high in that same cycle exactly when the current mask is all zero. The next-PC output shows the jump target when the branch is taken and the current PC plus one in every other cycle.
- R8: A taken jump with pop count n, where 0 < n <= number of entries, removes n entries and sets the mask to the entry that was n-th from the top. A jump with n = 0, or a jump that is not taken, leaves the stack and the mask unchanged.
- R9: A save while the stack holds DEPTH entries (default 8) sets the overflow flag and changes neither the stack nor the mask.
- R10: The underflow flag is set by an else on an empty stack, which leaves the mask unchanged. It is also set by a taken jump whose pop count exceeds the number of entries, which empties the stack and sets the mask to all ones.
- R11: Both error flags stay set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_code | input | 3 | Control operation, sampled in quarter-3 cycles |
| lane_pred | input | 64 | Per-lane compare outcome used by the predicate operation |
| pop_count | input | 4 | Number of stack levels a taken jump discards |
| cur_pc | input | 12 | Program counter of the current operation |
| jump_pc | input | 12 | Branch target of a jump |
| slice_idx | output | 2 | Quarter currently issued |
| slice_mask | output | 16 | Active-lane bits for that quarter |
| branch_taken | output | 1 | Jump taken in this cycle |
| next_pc | output | 12 | Jump target when taken, otherwise cur_pc + 1 |
| stack_overflow | output | 1 | Sticky flag: save on a full stack |
| stack_underflow | output | 1 | Sticky flag: else on an empty stack, or over-deep pop |

## Verification
A wrong mask or a wrong stack pointer never shows directly. It appears on the quarter outputs as wrong lane bits within the four cycles that follow the faulty operation. A stack entry that is wrong stays hidden until an else or a taken jump reads it, which can be many operations later. The sweep therefore compares all four quarters after every operation and mixes saves, narrowing predicates and multi-level pops so that saved entries are read back soon after they are written. A branch decided on the wrong mask shows in the same cycle on branch_taken and next_pc.

// File: rtl/dmask_pkg.sv
package dmask_pkg;

  typedef enum logic [2:0] {
    OPC_NONE = 3'd0,
    OPC_SAVE = 3'd1,
    OPC_PRED = 3'd2,
    OPC_FLIP = 3'd3,
    OPC_JUMP = 3'd4
  } ctl_op_e;

endpackage

// File: rtl/dmask_phase.sv
module dmask_phase #(
  parameter  int LANES    = 64,
  parameter  int SLICE    = 16,
  localparam int QUARTERS = LANES / SLICE,
  localparam int PH_W     = $clog2(QUARTERS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] mask_i,
  output logic [PH_W-1:0]  phase_o,
  output logic [SLICE-1:0] slice_o,
  output logic             last_o
);

  logic [PH_W-1:0] phase_q, phase_n;

  assign last_o = (phase_q == PH_W'(QUARTERS - 1));

  always_comb begin
    if (last_o) phase_n = '0;
    else        phase_n = phase_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_n;
  end

  always_comb begin
    slice_o = '0;
    for (int q = 0; q < QUARTERS; q++) begin
      if (phase_q == PH_W'(q)) slice_o = mask_i[q*SLICE +: SLICE];
    end
  end

  assign phase_o = phase_q;

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !last_o |=> phase_q == $past(phase_q) + PH_W'(1)); // R2
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> phase_q == '0); // R2

endmodule

// File: rtl/dmask_stack.sv
module dmask_stack #(
  parameter  int LANES = 64,
  parameter  int DEPTH = 8,
  localparam int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             clear_i,
  input  logic [SP_W-1:0]  pop_n_i,
  input  logic [LANES-1:0] wdata_i,
  output logic [SP_W-1:0]  sp_o,
  output logic [LANES-1:0] top_o,
  output logic [LANES-1:0] pick_o
);

  logic [SP_W-1:0]  sp_q, sp_n;
  logic [LANES-1:0] mem [DEPTH];
  logic [DEPTH-1:0] wen;
  logic [SP_W-1:0]  pick_pos;

  // One write-enabled register row per level.
  for (genvar i = 0; i < DEPTH; i++) begin : g_level
    assign wen[i] = push_i && (sp_q == SP_W'(i));
    always_ff @(posedge clk) begin
      if (wen[i]) mem[i] <= wdata_i;
    end
  end

  always_comb begin
    sp_n = sp_q;
    if (clear_i)     sp_n = '0;
    else if (push_i) sp_n = sp_q + SP_W'(1);
    else if (pop_i)  sp_n = sp_q - pop_n_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_n;
  end

  assign pick_pos = sp_q - pop_n_i;

  always_comb begin
    top_o  = '0;
    pick_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sp_q == SP_W'(i + 1)) top_o  = mem[i];
      if (pick_pos == SP_W'(i)) pick_o = mem[i];
    end
  end

  assign sp_o = sp_q;

  AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SP_W'(DEPTH)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> sp_q < SP_W'(DEPTH)); // R9
  AST_POP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (pop_n_i <= sp_q && pop_n_i != '0)); // R8
  AST_POP_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |=> sp_q == $past(sp_q) - $past(pop_n_i)); // R8

endmodule

// File: rtl/dmask_ctrl.sv
module dmask_ctrl
  import dmask_pkg::*;
#(
  parameter  int LANES = 64,
  parameter  int DEPTH = 8,
  parameter  int PC_W  = 12,
  localparam int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic [2:0]       op_i,
  input  logic [LANES-1:0] cmp_i,
  input  logic [SP_W-1:0]  pop_n_i,
  input  logic [PC_W-1:0]  cur_pc_i,
  input  logic [PC_W-1:0]  target_i,
  input  logic [SP_W-1:0]  sp_i,
  input  logic [LANES-1:0] top_i,
  input  logic [LANES-1:0] pick_i,
  output logic [LANES-1:0] mask_o,
  output logic             push_o,
  output logic             pop_o,
  output logic             clear_o,
  output logic             taken_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             ovf_o,
  output logic             unf_o
);

  ctl_op_e          op;
  logic [LANES-1:0] mask_q, mask_n;
  logic             ovf_q, ovf_n, unf_q, unf_n;
  logic             full, empty, none_active;

  assign op          = ctl_op_e'(op_i);
  assign full        = (sp_i == SP_W'(DEPTH));
  assign empty       = (sp_i == '0);
  assign none_active = ~|mask_q;

  always_comb begin
    mask_n  = mask_q;
    ovf_n   = ovf_q;
    unf_n   = unf_q;
    push_o  = 1'b0;
    pop_o   = 1'b0;
    clear_o = 1'b0;
    taken_o = 1'b0;
    if (accept_i) begin
      case (op)
        OPC_SAVE: begin
          if (full) ovf_n  = 1'b1;
          else      push_o = 1'b1;
        end
        OPC_PRED: mask_n = mask_q & cmp_i;
        OPC_FLIP: begin
          if (empty) unf_n  = 1'b1;
          else       mask_n = top_i & ~mask_q;
        end
        OPC_JUMP: begin
          if (none_active) begin
            taken_o = 1'b1;
            if (pop_n_i > sp_i) begin
              unf_n   = 1'b1;
              clear_o = 1'b1;
              mask_n  = '1;
            end else if (pop_n_i != '0) begin
              pop_o  = 1'b1;
              mask_n = pick_i;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign next_pc_o = taken_o ? target_i : cur_pc_i + PC_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      mask_q <= mask_n;
      ovf_q  <= ovf_n;
      unf_q  <= unf_n;
    end
  end

  assign mask_o = mask_q;
  assign ovf_o  = ovf_q;
  assign unf_o  = unf_q;

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> $stable(mask_q)); // R3
  AST_SAVE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> $stable(mask_q)); // R4
  AST_PRED_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && op == OPC_PRED) |=> (mask_q & ~$past(mask_q)) == '0); // R5
  AST_FLIP_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && op == OPC_FLIP) |=> $stable(sp_i)); // R6
  AST_TAKEN_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |=> sp_i <= $past(sp_i)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R11
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unf_q |=> unf_q); // R11

endmodule

// File: rtl/dmask_unit.sv
module dmask_unit #(
  parameter  int LANES = 64,
  parameter  int SLICE = 16,
  parameter  int DEPTH = 8,
  parameter  int PC_W  = 12,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int PH_W  = $clog2(LANES / SLICE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_code,
  input  logic [LANES-1:0] lane_pred,
  input  logic [SP_W-1:0]  pop_count,
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [PC_W-1:0]  jump_pc,
  output logic [PH_W-1:0]  slice_idx,
  output logic [SLICE-1:0] slice_mask,
  output logic             branch_taken,
  output logic [PC_W-1:0]  next_pc,
  output logic             stack_overflow,
  output logic             stack_underflow
);

  logic [1:0]       rsync_q;
  logic             rst_int_n;
  logic             accept;
  logic [LANES-1:0] mask;
  logic             push, pop, clear;
  logic [SP_W-1:0]  sp;
  logic [LANES-1:0] top, pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  dmask_phase #(.LANES(LANES), .SLICE(SLICE)) u_phase (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .mask_i  (mask),
    .phase_o (slice_idx),
    .slice_o (slice_mask),
    .last_o  (accept)
  );

  dmask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .push_i  (push),
    .pop_i   (pop),
    .clear_i (clear),
    .pop_n_i (pop_count),
    .wdata_i (mask),
    .sp_o    (sp),
    .top_o   (top),
    .pick_o  (pick)
  );

  dmask_ctrl #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .accept_i  (accept),
    .op_i      (op_code),
    .cmp_i     (lane_pred),
    .pop_n_i   (pop_count),
    .cur_pc_i  (cur_pc),
    .target_i  (jump_pc),
    .sp_i      (sp),
    .top_i     (top),
    .pick_i    (pick),
    .mask_o    (mask),
    .push_o    (push),
    .pop_o     (pop),
    .clear_o   (clear),
    .taken_o   (branch_taken),
    .next_pc_o (next_pc),
    .ovf_o     (stack_overflow),
    .unf_o     (stack_underflow)
  );

endmodule

// File: tb/dmask_unit_test.sv
`timescale 1ns/1ps
module dmask_unit_test;

  localparam int LANES = 64;
  localparam int SLICE = 16;
  localparam int DEPTH = 8;
  localparam int PC_W  = 12;

  logic             clk;
  logic             rst_n;
  logic [2:0]       op_code;
  logic [LANES-1:0] lane_pred;
  logic [3:0]       pop_count;
  logic [PC_W-1:0]  cur_pc;
  logic [PC_W-1:0]  jump_pc;
  logic [1:0]       slice_idx;
  logic [SLICE-1:0] slice_mask;
  logic             branch_taken;
  logic [PC_W-1:0]  next_pc;
  logic             stack_overflow;
  logic             stack_underflow;

  int checks = 0;
  int fails  = 0;

  // bench model
  logic [LANES-1:0] m;
  logic [LANES-1:0] ms [DEPTH];
  int               msp;
  logic             movf, munf;
  logic [31:0]      rng;

  dmask_unit uut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .lane_pred(lane_pred),
    .pop_count(pop_count), .cur_pc(cur_pc), .jump_pc(jump_pc),
    .slice_idx(slice_idx), .slice_mask(slice_mask), .branch_taken(branch_taken),
    .next_pc(next_pc), .stack_overflow(stack_overflow), .stack_underflow(stack_underflow)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic draw(output logic [31:0] v);
    rng = step(rng);
    v = rng;
  endtask

  task automatic read_mask(input string tag);
    for (int q = 0; q < 4; q++) begin
      if (q > 0) @(negedge clk);
      chk(slice_idx == 2'(q), "R2 quarter index", 64'(slice_idx), 64'(q));
      chk(slice_mask == m[q*SLICE +: SLICE], tag, 64'(slice_mask), 64'(m[q*SLICE +: SLICE]));
    end
  endtask

  task automatic wait_last();
    while (slice_idx != 2'd3) @(negedge clk);
  endtask

  task automatic do_reset();
    op_code = 3'd0; lane_pred = '0; pop_count = '0; cur_pc = '0; jump_pc = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(slice_idx == 2'd0, "R1 quarter after reset", 64'(slice_idx), 64'd0);
    chk(slice_mask == 16'hFFFF, "R1 mask after reset", 64'(slice_mask), 64'hFFFF);
    chk(!stack_overflow && !stack_underflow, "R1 flags after reset",
        64'({stack_overflow, stack_underflow}), 64'd0);
    m = '1; msp = 0; movf = 1'b0; munf = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // Drive one operation in a quarter-3 cycle, check branch outputs, then all quarters.
  task automatic apply(input logic [2:0] op, input logic [63:0] cmp,
                       input logic [3:0] pn, input logic [PC_W-1:0] pc,
                       input logic [PC_W-1:0] tgt);
    bit exp_taken;
    logic [PC_W-1:0] exp_pc;
    string tag;
    wait_last();
    op_code = op; lane_pred = cmp; pop_count = pn; cur_pc = pc; jump_pc = tgt;
    #1;
    exp_taken = (op == 3'd4) && (m == '0);
    exp_pc    = exp_taken ? tgt : pc + PC_W'(1);
    chk(branch_taken == exp_taken, "R7 branch taken", 64'(branch_taken), 64'(exp_taken));
    chk(next_pc == exp_pc, "R7 next pc", 64'(next_pc), 64'(exp_pc));
    tag = "R3 idle op";
    case (op)
      3'd1: begin
        tag = "R4 save";
        if (msp == DEPTH) begin movf = 1'b1; tag = "R9 full save"; end
        else begin ms[msp] = m; msp++; end
      end
      3'd2: begin tag = "R5 predicate"; m = m & cmp; end
      3'd3: begin
        tag = "R6 else";
        if (msp == 0) begin munf = 1'b1; tag = "R10 empty else"; end
        else m = ms[msp-1] & ~m;
      end
      3'd4: begin
        tag = "R8 jump";
        if (exp_taken) begin
          if (int'(pn) > msp) begin munf = 1'b1; msp = 0; m = '1; tag = "R10 deep pop"; end
          else if (pn != 0) begin msp = msp - int'(pn); m = ms[msp]; end
        end
      end
      default: ;
    endcase
    @(negedge clk);
    op_code = 3'd0;
    chk(stack_overflow == movf, "R9 R11 overflow flag", 64'(stack_overflow), 64'(movf));
    chk(stack_underflow == munf, "R10 R11 underflow flag", 64'(stack_underflow), 64'(munf));
    read_mask(tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] a, b, c, d;
    logic [2:0]  op;
    logic [63:0] cmp;
    rng = 32'h1234_5679;
    do_reset();

    // R2: quarter sequence with the reset mask
    wait_last();
    @(negedge clk);
    read_mask("R2 quarters of full mask");

    // R5 then R4, R6, R7 not taken, R8 pop
    apply(3'd2, 64'h0123_4567_89AB_CDEF, 4'd0, 12'h010, 12'h100);
    apply(3'd1, 64'h0, 4'd0, 12'h011, 12'h100);
    apply(3'd2, 64'hFFFF_0000_FFFF_0000, 4'd0, 12'h012, 12'h100);
    apply(3'd4, 64'h0, 4'd1, 12'h013, 12'h200);
    apply(3'd3, 64'h0, 4'd0, 12'h014, 12'h100);
    apply(3'd2, 64'h0, 4'd0, 12'h015, 12'h100);
    apply(3'd4, 64'h0, 4'd0, 12'h016, 12'h300);
    apply(3'd4, 64'h0, 4'd1, 12'h017, 12'h3A5);

    // R3: operation outside quarter 3 is ignored
    wait_last();
    @(negedge clk);
    @(negedge clk);
    op_code = 3'd2; lane_pred = '0;
    #1;
    chk(branch_taken == 1'b0, "R3 no branch off quarter 3", 64'(branch_taken), 64'd0);
    @(negedge clk);
    op_code = 3'd0;
    @(negedge clk);
    @(negedge clk);
    read_mask("R3 ignored predicate");

    // R9: fill past capacity
    for (int i = 0; i < DEPTH + 2; i++) apply(3'd1, 64'h0, 4'd0, 12'(i), 12'h0);
    apply(3'd2, 64'h0, 4'd0, 12'h020, 12'h0);
    apply(3'd4, 64'h0, 4'd3, 12'h021, 12'h444);

    // R10: empty else, then deep pop
    do_reset();
    apply(3'd3, 64'h0, 4'd0, 12'h030, 12'h0);
    apply(3'd1, 64'h0, 4'd0, 12'h031, 12'h0);
    apply(3'd2, 64'h0, 4'd0, 12'h032, 12'h0);
    apply(3'd4, 64'h0, 4'd5, 12'h033, 12'h555);
    apply(3'd7, 64'h0, 4'd0, 12'h034, 12'h0);

    // Sweep of mixed operations
    do_reset();
    for (int n = 0; n < 600; n++) begin
      if (n == 300) do_reset();
      draw(a); draw(b); draw(c); draw(d);
      case (a % 8)
        0, 4:    op = 3'd1;
        1, 5:    op = 3'd2;
        2:       op = 3'd3;
        3, 6:    op = 3'd4;
        default: op = 3'd6;
      endcase
      case ((a >> 8) % 4)
        0:       cmp = 64'h0;
        1:       cmp = '1;
        2:       cmp = {b, c};
        default: cmp = {b & c, c & d};
      endcase
      apply(op, cmp, 4'((a >> 12) % 10), d[PC_W-1:0], b[PC_W+3:4]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule